// File: doc/BRIEF.md
# Qualified Event Performance Counter Bank

This block holds a bank of wide event counters for processor performance monitoring. Each counter has its own configuration word. The word picks one lane from a vector of per-cycle event counts and sets the rules under which that lane advances the counter. The lane value is gated by a counter enable, a privilege-level filter and a cache-line-state mask.

The gated value then reaches the counter in one of two ways:
- **Count mode:** the raw per-cycle count is added.
- **Threshold mode:** a compare against a threshold, which can be inverted, decides whether the counter advances by one. An optional rising-edge filter turns a condition that lasts many cycles into a single step.

Software reads and writes every counter, every configuration word and every overflow flag through a plain address/data port. A wrap from all ones to zero sets a sticky flag. The flag drives that counter's interrupt line when interrupts are enabled for it.

Top module: `evq_counter_bank`

## Requirements
- R1: After reset, every counter, configuration word and overflow flag reads zero, and all interrupt outputs are low.
- R2: The register address is {counter index, 2-bit select}. The selects are:
  - select 0: the 48-bit counter.
  - select 1: the configuration word. Its fields are enable [0], interrupt enable [1], OS enable [2], USR enable [3], edge [4], invert [5], unit mask [10:6], threshold [23:16] and event select [31:24]. Bits [15:11] read zero.
  - select 2: the overflow flag in bit 0.
  - select 3: reads zero.

  Writes take effect at the next clock edge. A counter write overrides any increment in that same cycle.
- R3: While a counter's enable bit is 0, its value does not change except by a software write.
- R4: With threshold 0 (count mode), each qualified cycle adds the selected raw per-cycle event count. Invert and edge have no effect in this mode.
- R5: With a nonzero threshold and invert 0, the counter advances by one in each qualified cycle whose selected count is greater than or equal to the threshold.
- R6: With a nonzero threshold and invert 1, the counter advances by one in each qualified cycle whose selected count is less than the threshold.
- R7: With a nonzero threshold and edge 1, the counter advances by one only in a cycle where the qualified condition is true and was false in the previous cycle.
- R8: Privilege input 0 is counted only when OS enable is set. Inputs 1, 2 and 3 are counted only when USR enable is set. With both enables clear, all levels are counted.
- R9: The line-state input is one-hot, with bit 0 for Modified, 1 for Owner, 2 for Exclusive, 3 for Shared and 4 for Invalid. The unit mask uses the same bit order. A cycle qualifies when the mask and the state share a set bit. A zero mask qualifies every cycle, whatever the state.
- R10: A counter wrap from all ones past zero sets that counter's sticky overflow flag. Writing 1 to bit 0 of the flag clears it, and writing 0 leaves it set. The interrupt line is high exactly while the flag is set and interrupt enable is 1.
- R11: The event select field chooses which lane of the event vector feeds the counter. Lane k occupies bits [3k+2:3k], and a select of 8 or above counts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_cnt | input | 24 | Eight 3-bit per-cycle event counts |
| priv | input | 2 | Current privilege level |
| line_state | input | 5 | One-hot cache-line state of the current event |
| reg_addr | input | 4 | Register address {index, select} |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 48 | Write data |
| reg_rdata | output | 48 | Read data for reg_addr, combinational |
| irq | output | 4 | Per-counter interrupt |

## Verification
The assertions check four things on every cycle:
- a disabled counter holds its value;
- a counter in threshold mode moves by at most one per cycle;
- an edge-mode counter never steps in two consecutive cycles;
- a counter write lands exactly, and overflow flags stay set until cleared, rise only just after a wrap, and stand behind every interrupt.

The values themselves can only be shown by the bench's sweeps, which compare each count against arithmetic in the bench. These sweeps cover:
- every threshold against every count in both senses;
- all unit masks against every line state;
- every privilege level against every enable pair;
- lane selection and the exact wrap boundary.

// File: rtl/evq_pkg.sv
`timescale 1ns/1ps
package evq_pkg;

  // Configuration word, 32 bits; field order fixes the software layout.
  typedef struct packed {
    logic [7:0] evsel;    // [31:24]
    logic [7:0] thr;      // [23:16]
    logic [4:0] rsvd;     // [15:11]
    logic [4:0] umask;    // [10:6]  bit0 M, 1 O, 2 E, 3 S, 4 I
    logic       inv;      // [5]
    logic       edge_md;  // [4]
    logic       usr_en;   // [3]
    logic       os_en;    // [2]
    logic       irq_en;   // [1]
    logic       en;       // [0]
  } evq_cfg_t;

  localparam int CFG_W = $bits(evq_cfg_t);

  function automatic evq_cfg_t cfg_from_word(input logic [CFG_W-1:0] w);
    evq_cfg_t c;
    c = evq_cfg_t'(w);
    c.rsvd = '0;
    return c;
  endfunction

  // Level 0 needs the OS enable, 1..3 the USR enable; none set means all.
  function automatic logic priv_pass(input evq_cfg_t c, input logic [1:0] pl);
    logic both_off;
    both_off = !c.os_en && !c.usr_en;
    if (both_off) return 1'b1;
    return (pl == 2'd0) ? c.os_en : c.usr_en;
  endfunction

  function automatic logic state_pass(input logic [4:0] m, input logic [4:0] st);
    return (m == 5'd0) || ((m & st) != 5'd0);
  endfunction

  function automatic logic thr_pass(input logic [7:0] cnt, input logic [7:0] thr,
                                    input logic inv);
    return inv ? (cnt < thr) : (cnt >= thr);
  endfunction

endpackage

// File: rtl/evq_qual.sv
`timescale 1ns/1ps
module evq_qual
  import evq_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int EVT_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  evq_cfg_t                 cfg,
  input  logic [NUM_EVT*EVT_W-1:0] evt_cnt,
  input  logic [1:0]               priv,
  input  logic [4:0]               line_state,
  output logic [EVT_W-1:0]         inc_amt,
  output logic                     cond_now,
  output logic                     edge_fire
);

  logic [EVT_W-1:0] sel_cnt;
  logic             gate;
  logic             count_mode;
  logic             prev_cond;

  always_comb begin
    sel_cnt = '0;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (cfg.evsel == 8'(k)) sel_cnt = evt_cnt[k*EVT_W +: EVT_W];
    end
  end

  assign gate       = cfg.en && priv_pass(cfg, priv) && state_pass(cfg.umask, line_state);
  assign count_mode = (cfg.thr == 8'd0);
  assign cond_now   = gate && thr_pass(8'(sel_cnt), cfg.thr, cfg.inv);
  assign edge_fire  = cond_now && !prev_cond;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_cond <= 1'b0;
    else        prev_cond <= cond_now;
  end

  always_comb begin
    if (count_mode)       inc_amt = gate ? sel_cnt : '0;
    else if (cfg.edge_md) inc_amt = EVT_W'(edge_fire);
    else                  inc_amt = EVT_W'(cond_now);
  end

endmodule

// File: rtl/evq_slice.sv
`timescale 1ns/1ps
module evq_slice
  import evq_pkg::*;
#(
  parameter int CTR_W = 48,
  parameter int EVT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctr_wr,
  input  logic             cfg_wr,
  input  logic             clr_wr,
  input  logic [CTR_W-1:0] wdata,
  input  logic [EVT_W-1:0] inc_amt,
  output logic [CTR_W-1:0] ctr,
  output evq_cfg_t         cfg,
  output logic             flag,
  output logic             irq,
  output logic             wrap
);

  logic [CTR_W:0] sum;

  assign sum  = {1'b0, ctr} + (CTR_W+1)'(inc_amt);
  assign wrap = sum[CTR_W] && !ctr_wr;
  assign irq  = flag && cfg.irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctr  <= '0;
      cfg  <= '0;
      flag <= 1'b0;
    end else begin
      ctr <= ctr_wr ? wdata : sum[CTR_W-1:0];
      if (cfg_wr) cfg <= cfg_from_word(wdata[CFG_W-1:0]);
      if (wrap)        flag <= 1'b1;
      else if (clr_wr) flag <= 1'b0;
    end
  end

endmodule

// File: rtl/evq_regif.sv
`timescale 1ns/1ps
module evq_regif
  import evq_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 48,
  parameter int ADDR_W  = 4
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr,
  input  logic                     wbit0,
  input  logic [NUM_CTR*CTR_W-1:0] ctr_flat,
  input  logic [NUM_CTR*CFG_W-1:0] cfg_flat,
  input  logic [NUM_CTR-1:0]       flag,
  output logic [NUM_CTR-1:0]       ctr_wr,
  output logic [NUM_CTR-1:0]       cfg_wr,
  output logic [NUM_CTR-1:0]       clr_wr,
  output logic [CTR_W-1:0]         rdata
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [1:0]       sel;
  logic [NUM_CTR-1:0] hit;

  assign idx = addr[ADDR_W-1:2];
  assign sel = addr[1:0];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_dec
    assign hit[i]    = (idx == IDX_W'(i));
    assign ctr_wr[i] = wr && hit[i] && (sel == 2'd0);
    assign cfg_wr[i] = wr && hit[i] && (sel == 2'd1);
    assign clr_wr[i] = wr && hit[i] && (sel == 2'd2) && wbit0;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (hit[i]) begin
        case (sel)
          2'd0:    rdata = ctr_flat[i*CTR_W +: CTR_W];
          2'd1:    rdata = CTR_W'(cfg_flat[i*CFG_W +: CFG_W]);
          2'd2:    rdata = CTR_W'(flag[i]);
          default: rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/evq_counter_bank.sv
`timescale 1ns/1ps
module evq_counter_bank
  import evq_pkg::*;
#(
  parameter int NUM_CTR = 4,                     // at least 2
  parameter int CTR_W   = 48,                    // at least 32 (config readback)
  parameter int NUM_EVT = 8,                     // at most 256
  parameter int EVT_W   = 3,                     // at most 8
  parameter int ADDR_W  = $clog2(NUM_CTR) + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_EVT*EVT_W-1:0] evt_cnt,
  input  logic [1:0]               priv,
  input  logic [4:0]               line_state,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic                     reg_wr,
  input  logic [CTR_W-1:0]         reg_wdata,
  output logic [CTR_W-1:0]         reg_rdata,
  output logic [NUM_CTR-1:0]       irq
);

  // Named internal events for the checker.
  logic [NUM_CTR*CTR_W-1:0] ctr_flat;
  logic [NUM_CTR*CFG_W-1:0] cfg_flat;
  logic [NUM_CTR*EVT_W-1:0] inc_flat;
  logic [NUM_CTR-1:0]       ovf_flag;
  logic [NUM_CTR-1:0]       wrap_ev;
  logic [NUM_CTR-1:0]       ctr_wr;
  logic [NUM_CTR-1:0]       cfg_wr;
  logic [NUM_CTR-1:0]       clr_wr;
  logic [NUM_CTR-1:0]       en_bits;
  logic [NUM_CTR-1:0]       edge_bits;
  logic [NUM_CTR-1:0]       thr_nz;
  logic [NUM_CTR-1:0]       cond_bits;
  logic [NUM_CTR-1:0]       fire_bits;

  evq_regif #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W),
    .ADDR_W  (ADDR_W)
  ) u_regif (
    .addr     (reg_addr),
    .wr       (reg_wr),
    .wbit0    (reg_wdata[0]),
    .ctr_flat (ctr_flat),
    .cfg_flat (cfg_flat),
    .flag     (ovf_flag),
    .ctr_wr   (ctr_wr),
    .cfg_wr   (cfg_wr),
    .clr_wr   (clr_wr),
    .rdata    (reg_rdata)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    evq_cfg_t         cfg_q;
    logic [CTR_W-1:0] ctr_q;
    logic [EVT_W-1:0] inc_amt;

    evq_qual #(
      .NUM_EVT (NUM_EVT),
      .EVT_W   (EVT_W)
    ) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg        (cfg_q),
      .evt_cnt    (evt_cnt),
      .priv       (priv),
      .line_state (line_state),
      .inc_amt    (inc_amt),
      .cond_now   (cond_bits[i]),
      .edge_fire  (fire_bits[i])
    );

    evq_slice #(
      .CTR_W (CTR_W),
      .EVT_W (EVT_W)
    ) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctr_wr  (ctr_wr[i]),
      .cfg_wr  (cfg_wr[i]),
      .clr_wr  (clr_wr[i]),
      .wdata   (reg_wdata),
      .inc_amt (inc_amt),
      .ctr     (ctr_q),
      .cfg     (cfg_q),
      .flag    (ovf_flag[i]),
      .irq     (irq[i]),
      .wrap    (wrap_ev[i])
    );

    assign ctr_flat[i*CTR_W +: CTR_W] = ctr_q;
    assign cfg_flat[i*CFG_W +: CFG_W] = CFG_W'(cfg_q);
    assign inc_flat[i*EVT_W +: EVT_W] = inc_amt;
    assign en_bits[i]   = cfg_q.en;
    assign edge_bits[i] = cfg_q.edge_md;
    assign thr_nz[i]    = (cfg_q.thr != 8'd0);
  end

endmodule

// File: rtl/evq_counter_bank_chk.sv
`timescale 1ns/1ps
module evq_counter_bank_chk #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 48,
  parameter int EVT_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [CTR_W-1:0]         reg_wdata,
  input logic [NUM_CTR-1:0]       irq,
  input logic [NUM_CTR*CTR_W-1:0] ctr_flat,
  input logic [NUM_CTR*EVT_W-1:0] inc_flat,
  input logic [NUM_CTR-1:0]       ovf_flag,
  input logic [NUM_CTR-1:0]       ctr_wr,
  input logic [NUM_CTR-1:0]       clr_wr,
  input logic [NUM_CTR-1:0]       en_bits,
  input logic [NUM_CTR-1:0]       edge_bits,
  input logic [NUM_CTR-1:0]       thr_nz
);

  logic [NUM_CTR*CTR_W-1:0] ctr_d1;

  always_ff @(posedge clk) begin
    if (!rst_n) ctr_d1 <= '0;
    else        ctr_d1 <= ctr_flat;
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    logic [CTR_W-1:0] cur;
    logic [CTR_W-1:0] step;
    assign cur  = ctr_flat[i*CTR_W +: CTR_W];
    assign step = cur - ctr_d1[i*CTR_W +: CTR_W];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_wr[i] |=> (cur == $past(reg_wdata))); // R2
    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_bits[i] && !ctr_wr[i]) |=> (step == '0)); // R3
    AST_THRESHOLD_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_nz[i] && !ctr_wr[i]) |=> (step <= CTR_W'(1))); // R5
    AST_EDGE_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_bits[i] && thr_nz[i] && !ctr_wr[i] && (inc_flat[i*EVT_W +: EVT_W] != '0))
      |=> (!(edge_bits[i] && thr_nz[i]) || (inc_flat[i*EVT_W +: EVT_W] == '0))); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag[i] && !clr_wr[i]) |=> ovf_flag[i]); // R10
    AST_FLAG_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag[i]) |-> (cur < CTR_W'(1 << EVT_W))); // R10
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> ovf_flag[i]); // R10
  end

endmodule

bind evq_counter_bank evq_counter_bank_chk #(
  .NUM_CTR (NUM_CTR),
  .CTR_W   (CTR_W),
  .EVT_W   (EVT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .ctr_flat  (ctr_flat),
  .inc_flat  (inc_flat),
  .ovf_flag  (ovf_flag),
  .ctr_wr    (ctr_wr),
  .clr_wr    (clr_wr),
  .en_bits   (en_bits),
  .edge_bits (edge_bits),
  .thr_nz    (thr_nz)
);

// File: tb/test_evq_counter_bank.sv
`timescale 1ns/1ps
module test_evq_counter_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] evt_cnt = '0;
  logic [1:0]  priv = 2'd0;
  logic [4:0]  line_state = 5'd0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [47:0] reg_wdata = '0;
  logic [47:0] reg_rdata;
  logic [3:0]  irq;

  int checks = 0;
  int failures = 0;
  logic [23:0] seq [8];
  int seq_len;

  always #5 clk = ~clk;

  evq_counter_bank i_evq_counter_bank (
    .clk, .rst_n, .evt_cnt, .priv, .line_state,
    .reg_addr, .reg_wr, .reg_wdata, .reg_rdata, .irq
  );

  function automatic logic [31:0] mk_cfg(input logic irqe, os, usr, edg, inv,
                                         input logic [4:0] mask, input logic [7:0] thr,
                                         input logic [7:0] sel);
    return {sel, thr, 5'd0, mask, inv, edg, usr, os, irqe, 1'b0};
  endfunction

  // Expected count from the requirements, one cycle at a time.
  function automatic logic [47:0] model(input logic [31:0] cw);
    logic [47:0] acc = '0;
    logic prev = 1'b0;
    logic [7:0] thr = cw[23:16];
    logic [7:0] sel = cw[31:24];
    logic [4:0] mask = cw[10:6];
    logic os = cw[2], usr = cw[3];
    for (int j = 0; j < seq_len; j++) begin
      int v;
      logic ok, cond;
      v = (sel < 8) ? int'((seq[j] >> (3*sel)) & 24'd7) : 0;
      ok = (!os && !usr) || (priv == 0 ? os : usr);
      ok = ok && (mask == 0 || (mask & line_state) != 0);
      if (thr == 0) begin
        if (ok) acc += 48'(v);
      end else begin
        cond = ok && (cw[5] ? (v < int'(thr)) : (v >= int'(thr)));
        if (cw[4]) begin
          if (cond && !prev) acc += 1;
        end else if (cond) acc += 1;
        prev = cond;
      end
    end
    return acc;
  endfunction

  task automatic chk(input string req, input string what, input logic [47:0] act, exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [47:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [47:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Preset counter c, enable cfg for exactly seq_len counted cycles, disable.
  task automatic run_seq(input int c, input logic [31:0] cw, input logic [47:0] preset,
                         output logic [47:0] result);
    wr(4'(c*4), preset);
    reg_addr = 4'(c*4+1); reg_wdata = 48'(cw | 32'd1); reg_wr = 1'b1; evt_cnt = '0;
    @(negedge clk);
    for (int j = 0; j < seq_len; j++) begin
      evt_cnt = seq[j];
      if (j == seq_len - 1) begin reg_wdata = 48'(cw & ~32'd1); reg_wr = 1'b1; end
      else reg_wr = 1'b0;
      @(negedge clk);
    end
    reg_wr = 1'b0; evt_cnt = '0;
    rd(4'(c*4), result);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [47:0] r;
    logic [31:0] cw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of every address and every interrupt
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), r);
      chk("R1", "reset read", r, 48'd0);
    end
    chk("R1", "reset irq", 48'(irq), 48'd0);

    // R2: config readback with reserved bits zero
    wr(4'd5, 48'hFFFF_FFFF);
    rd(4'd5, r);
    chk("R2", "cfg readback", r, 48'hFFFF_07FF);
    wr(4'd5, 48'd0);

    // R2: counter write overrides a same-cycle increment
    wr(4'd8, 48'd0);
    @(negedge clk); evt_cnt = 24'd7;
    wr(4'd9, 48'h1);
    wr(4'd8, 48'd100);
    rd(4'd8, r);
    chk("R2", "write wins", r, 48'd100);
    @(negedge clk);
    rd(4'd8, r);
    chk("R2", "count after write", r, 48'd107);
    evt_cnt = '0;
    wr(4'd9, 48'h0);

    // R3: disabled counter ignores events
    wr(4'd12, 48'd5);
    @(negedge clk); evt_cnt = 24'hFFFFFF;
    repeat (5) @(negedge clk);
    evt_cnt = '0;
    rd(4'd12, r);
    chk("R3", "disabled hold", r, 48'd5);

    // R4: count mode adds raw counts; invert and edge ignored
    seq[0] = 24'd3; seq[1] = 24'd7; seq[2] = 24'd0; seq[3] = 24'd5; seq_len = 4;
    run_seq(1, mk_cfg(0,0,0,0,0,5'd0,8'd0,8'd0), 48'd10, r);
    chk("R4", "count mode sum", r, 48'd25);
    run_seq(2, mk_cfg(0,0,0,1,1,5'd0,8'd0,8'd0), 48'd0, r);
    chk("R4", "count mode edge+inv", r, 48'd15);

    // R5, R6: every threshold against every count, both senses
    seq_len = 1;
    for (int t = 1; t < 8; t++)
      for (int iv = 0; iv < 2; iv++)
        for (int v = 0; v < 8; v++) begin
          seq[0] = 24'(v);
          cw = mk_cfg(0,0,0,0,1'(iv),5'd0,8'(t),8'd0);
          run_seq(t % 4, cw, 48'd0, r);
          chk(iv ? "R6" : "R5", "threshold compare", r, model(cw));
        end

    // R7: edge mode counts rising edges of the condition only
    seq[0] = 24'd5; seq[1] = 24'd5; seq[2] = 24'd5; seq[3] = 24'd0;
    seq[4] = 24'd6; seq[5] = 24'd6; seq[6] = 24'd1; seq[7] = 24'd7; seq_len = 8;
    cw = mk_cfg(0,0,0,1,0,5'd0,8'd4,8'd0);
    run_seq(3, cw, 48'd0, r);
    chk("R7", "edge count", r, 48'd3);
    chk("R7", "edge model", r, model(cw));
    cw = mk_cfg(0,0,0,0,0,5'd0,8'd4,8'd0);
    run_seq(3, cw, 48'd0, r);
    chk("R7", "level count same seq", r, 48'd6);
    cw = mk_cfg(0,0,0,1,1,5'd0,8'd4,8'd0);
    run_seq(0, cw, 48'd0, r);
    chk("R7", "edge inverted", r, model(cw));

    // R8: privilege filter sweep
    seq[0] = 24'd3; seq_len = 1;
    for (int p = 0; p < 4; p++)
      for (int oe = 0; oe < 4; oe++) begin
        priv = 2'(p);
        cw = mk_cfg(0,oe[0],oe[1],0,0,5'd0,8'd0,8'd0);
        run_seq(p, cw, 48'd0, r);
        chk("R8", "privilege", r, model(cw));
      end
    priv = 2'd0;

    // R9: unit mask sweep against each one-hot state and no state
    for (int m = 0; m < 32; m++)
      for (int s = 0; s < 6; s++) begin
        line_state = (s < 5) ? 5'(1 << s) : 5'd0;
        cw = mk_cfg(0,0,0,0,0,5'(m),8'd0,8'd0);
        run_seq(m % 4, cw, 48'd0, r);
        chk("R9", "unit mask", r, model(cw));
      end
    line_state = 5'd0;

    // R11: lane selection with distinct values per lane
    for (int k = 0; k < 9; k++) begin
      for (int j = 0; j < 2; j++) begin
        seq[j] = '0;
        for (int l = 0; l < 8; l++) seq[j][3*l +: 3] = 3'((l*3 + 1 + j) % 8);
      end
      seq_len = 2;
      cw = mk_cfg(0,0,0,0,0,5'd0,8'd0,8'(k == 8 ? 200 : k));
      run_seq(k % 4, cw, 48'd0, r);
      chk("R11", "event select", r, model(cw));
    end

    // R10: wrap boundary, flag, irq, clear
    seq[0] = 24'd1; seq_len = 1;
    run_seq(2, mk_cfg(1,0,0,0,0,5'd0,8'd0,8'd0), 48'hFFFF_FFFF_FFFE, r);
    chk("R10", "no wrap at max", r, 48'hFFFF_FFFF_FFFF);
    rd(4'd10, r);
    chk("R10", "no flag at max", r, 48'd0);
    run_seq(2, mk_cfg(1,0,0,0,0,5'd0,8'd0,8'd0), 48'hFFFF_FFFF_FFFF, r);
    chk("R10", "wrap to zero", r, 48'd0);
    rd(4'd10, r);
    chk("R10", "flag set", r, 48'd1);
    chk("R10", "irq high", 48'(irq), 48'b0100);
    seq[0] = 24'd3;
    run_seq(2, mk_cfg(1,0,0,0,0,5'd0,8'd0,8'd0), 48'd5, r);
    rd(4'd10, r);
    chk("R10", "flag sticky", r, 48'd1);
    wr(4'd10, 48'd0);
    rd(4'd10, r);
    chk("R10", "write 0 keeps", r, 48'd1);
    wr(4'd10, 48'd1);
    rd(4'd10, r);
    chk("R10", "write 1 clears", r, 48'd0);
    chk("R10", "irq low", 48'(irq), 48'd0);
    run_seq(1, mk_cfg(0,0,0,0,0,5'd0,8'd0,8'd0), 48'hFFFF_FFFF_FFFE, r);
    chk("R10", "wrap by 3", r, 48'd1);
    rd(4'd6, r);
    chk("R10", "flag no irq_en", r, 48'd1);
    chk("R10", "irq masked", 48'(irq), 48'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule